// File: doc/BRIEF.md
# Frame-Sync Driven Power-State Controller

This block decides whether a codec's digital core is powered. It comes out of reset in the powered-down state. It wakes on the first rising edge seen on either frame sync, the transmit one or the receive one, provided the power-down pin permits operation. The pin permits operation when it is low, and also when it is toggling. Toggling means that an edge on the synchronised pin has been seen within the last `TOGGLE_WIN` master-clock cycles. A pin that sits high for longer than that window forces the core down.

While powered, the block times the gap since the most recent frame-sync edge. If neither frame sync rises for `IDLE_CYCLES` master-clock cycles, the core goes back down. The default value stands for roughly one millisecond at a 2.048 MHz master clock.

The block also produces a permit for the transmit data driver. After each wake-up, the driver is held off (output floating) until the `HOLD_FRAMES`-th transmit frame-sync edge has been counted. Both frame syncs are taken as synchronous to the master clock. The pin is asynchronous and passes through a synchroniser.

Top module: `fspd_ctrl`

## Requirements
- R1: In the cycle after reset has been applied, `power_good` and `tx_permit` are both 0.
- R2: While powered down and permitted by the pin, a rising edge on `fs_tx` or `fs_rx` sets `power_good` to 1 at the same clock edge that samples the frame sync high (visible in the following cycle).
- R3: When `pdn_pin` goes high and stays high, `power_good` is still 1 for at least `TOGGLE_WIN` cycles. It is 0 no later than `TOGGLE_WIN`+6 cycles after the change. While the pin stays high, frame-sync edges do not wake the core.
- R4: A `pdn_pin` that changes level at least once every `TOGGLE_WIN` cycles counts the same as a low pin: a frame-sync edge wakes the core, and the core stays powered.
- R5: Once powered, `power_good` falls exactly `IDLE_CYCLES` clock edges after the last frame-sync rising edge. Any rising edge on either frame sync restarts that count.
- R6: `tx_permit` goes to 1 at the clock edge that counts the `HOLD_FRAMES`-th (default 2) `fs_tx` rising edge since wake-up. The waking edge counts when it is on `fs_tx`. Edges on `fs_rx` and a frame sync held high do not count.
- R7: `tx_permit` is never 1 while `power_good` is 0. It falls with power-down, and the frame count starts again from zero at the next wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_pin | input | 1 | Power-down pin, asynchronous; high requests power-down |
| fs_tx | input | 1 | Transmit frame sync, active high |
| fs_rx | input | 1 | Receive frame sync, active high |
| power_good | output | 1 | 1 while the core is powered |
| tx_permit | output | 1 | 1 when the transmit data output may drive |

## Verification
A table of frame-sync patterns is walked first. It wakes the core through the receive sync, holds the transmit sync high across several cycles, and interleaves receive pulses between transmit pulses. This separates edge counting from level counting and shows whether receive edges leak into the transmit frame count.

Directed sequences follow. One lets the frame syncs go silent and checks the exact cycle of the timeout against a restarted gap. One wakes through the transmit sync, so that the waking edge is counted. The last compares a pin that is steadily high with a pin that toggles faster than the window: the first must block wake-up, the second must not.

// File: rtl/fspd_pkg.sv
package fspd_pkg;

    typedef enum logic {
        PS_DOWN = 1'b0,
        PS_UP   = 1'b1
    } pstate_e;

    typedef struct packed {
        logic tx_rise;
        logic rx_rise;
    } fs_edges_t;

    // width able to hold values 0..n
    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fspd_pin_mon.sv
module fspd_pin_mon #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TOGGLE_WIN  = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_pin,
    output logic allow
);
    localparam int unsigned WW = fspd_pkg::cw(TOGGLE_WIN);
    localparam logic [WW-1:0] WIN_V = WW'(TOGGLE_WIN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    logic                   pin_q;
    logic                   pin_edge;
    logic [WW-1:0]          since_edge;
    logic                   toggling;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pdn_pin};
        end
    end

    assign pin_s    = sync_q[SYNC_STAGES-1];
    assign pin_edge = pin_s ^ pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q      <= 1'b0;
            since_edge <= WIN_V;
        end else begin
            pin_q <= pin_s;
            if (pin_edge) begin
                since_edge <= '0;
            end else if (since_edge != WIN_V) begin
                since_edge <= since_edge + 1'b1;
            end
        end
    end

    assign toggling = pin_edge | (since_edge < WIN_V);
    assign allow    = ~pin_s | toggling;

endmodule

// File: rtl/fspd_activity.sv
module fspd_activity #(
    parameter int unsigned IDLE_CYCLES = 2048
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fs_tx,
    input  logic                fs_rx,
    input  logic                run,
    output fspd_pkg::fs_edges_t edges,
    output logic                expire
);
    localparam int unsigned CW = fspd_pkg::cw(IDLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic          tx_q;
    logic          rx_q;
    logic          any_rise;
    logic [CW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            tx_q <= fs_tx;
            rx_q <= fs_rx;
        end
    end

    assign edges.tx_rise = fs_tx & ~tx_q;
    assign edges.rx_rise = fs_rx & ~rx_q;
    assign any_rise      = edges.tx_rise | edges.rx_rise;

    always_ff @(posedge clk) begin
        if (rst || !run || any_rise) begin
            gap_cnt <= '0;
        end else if (gap_cnt != LAST) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign expire = run & ~any_rise & (gap_cnt == LAST);

    // R5: a timeout is only reported after the full gap has been counted
    a_r5_expire_after_gap: assert property (@(posedge clk) disable iff (rst)
        expire |-> $past(run) && !$past(any_rise));

endmodule

// File: rtl/fspd_txgate.sv
module fspd_txgate #(
    parameter int unsigned HOLD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic up,
    input  logic wake,
    input  logic tx_rise,
    output logic permit
);
    localparam int unsigned HW = fspd_pkg::cw(HOLD_FRAMES);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_FRAMES);

    logic [HW-1:0] frames;

    always_ff @(posedge clk) begin
        if (rst) begin
            frames <= '0;
        end else if (wake) begin
            frames <= tx_rise ? HW'(1) : '0;
        end else if (!up) begin
            frames <= '0;
        end else if (tx_rise && frames != HOLD_V) begin
            frames <= frames + 1'b1;
        end
    end

    assign permit = up & (frames == HOLD_V);

    // R6: the permit only opens at an edge that counted a transmit frame
    a_r6_open_on_tx_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(permit) |-> $past(tx_rise));

endmodule

// File: rtl/fspd_ctrl.sv
module fspd_ctrl #(
    parameter int unsigned IDLE_CYCLES = 2048,
    parameter int unsigned TOGGLE_WIN  = 64,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pdn_pin,
    input  logic fs_tx,
    input  logic fs_rx,
    output logic power_good,
    output logic tx_permit
);
    import fspd_pkg::*;

    pstate_e   state_q;
    pstate_e   state_d;
    logic      allow;
    fs_edges_t edges;
    logic      any_rise;
    logic      expire;
    logic      wake;
    logic      rst_q;

    fspd_pin_mon #(
        .SYNC_STAGES (SYNC_STAGES),
        .TOGGLE_WIN  (TOGGLE_WIN)
    ) u_pin (
        .clk     (clk),
        .rst     (rst),
        .pdn_pin (pdn_pin),
        .allow   (allow)
    );

    fspd_activity #(
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_act (
        .clk    (clk),
        .rst    (rst),
        .fs_tx  (fs_tx),
        .fs_rx  (fs_rx),
        .run    (power_good),
        .edges  (edges),
        .expire (expire)
    );

    assign any_rise = edges.tx_rise | edges.rx_rise;
    assign wake     = (state_q == PS_DOWN) & allow & any_rise;

    always_comb begin
        state_d = state_q;
        if (!allow) begin
            state_d = PS_DOWN;
        end else if (wake) begin
            state_d = PS_UP;
        end else if (state_q == PS_UP && expire) begin
            state_d = PS_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    assign power_good = (state_q == PS_UP);

    fspd_txgate #(
        .HOLD_FRAMES (HOLD_FRAMES)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .up      (power_good),
        .wake    (wake),
        .tx_rise (edges.tx_rise),
        .permit  (tx_permit)
    );

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: outputs are quiet right after reset
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_quiet: assert (!power_good && !tx_permit);
        end
    end

    // R2: a permitted frame-sync edge wakes the core
    a_r2_wake_on_edge: assert property (@(posedge clk) disable iff (rst)
        (!power_good && allow && any_rise) |=> power_good);

    // R3: a blocking pin level takes the core down
    a_r3_pin_forces_down: assert property (@(posedge clk) disable iff (rst)
        !allow |=> !power_good);

    // R5: a frame-sync edge while powered keeps the core up
    a_r5_edge_keeps_up: assert property (@(posedge clk) disable iff (rst)
        (power_good && allow && any_rise) |=> power_good);

    // R7: the transmit permit needs power
    a_r7_permit_needs_power: assert property (@(posedge clk) disable iff (rst)
        tx_permit |-> power_good);

endmodule

// File: tb/sim_fspd_ctrl.sv
module sim_fspd_ctrl;

    localparam int IDLE = 40;
    localparam int WIN  = 8;
    localparam int NVEC = 12;

    // fields: {fs_tx, fs_rx, expected power_good, expected tx_permit}
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0000, 4'b0110, 4'b0010, 4'b1010,
        4'b1010, 4'b0010, 4'b0110, 4'b0010,
        4'b1011, 4'b0011, 4'b1011, 4'b0011
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pdn_pin = 1'b0;
    logic fs_tx = 1'b0;
    logic fs_rx = 1'b0;
    logic power_good;
    logic tx_permit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fspd_ctrl #(
        .IDLE_CYCLES (IDLE),
        .TOGGLE_WIN  (WIN),
        .SYNC_STAGES (2),
        .HOLD_FRAMES (2)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .pdn_pin    (pdn_pin),
        .fs_tx      (fs_tx),
        .fs_rx      (fs_rx),
        .power_good (power_good),
        .tx_permit  (tx_permit)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pulse_tx();
        fs_tx = 1'b1;
        @(negedge clk);
        fs_tx = 1'b0;
    endtask

    task automatic pulse_rx();
        fs_rx = 1'b1;
        @(negedge clk);
        fs_rx = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 power_good after reset", power_good, 1'b0);
        chk("R1 tx_permit after reset", tx_permit, 1'b0);

        // table walk: wake through fs_rx, then count fs_tx frames (R2 R6)
        for (int i = 0; i < NVEC; i++) begin
            fs_tx = VEC[i][3];
            fs_rx = VEC[i][2];
            @(negedge clk);
            chk($sformatf("R2 vector %0d power_good", i), power_good, VEC[i][1]);
            chk($sformatf("R6 vector %0d tx_permit", i), tx_permit, VEC[i][0]);
        end
        fs_tx = 1'b0;
        fs_rx = 1'b0;

        // R5: exact timeout after the last edge
        pulse_tx();
        repeat (IDLE - 1) @(negedge clk);
        chk("R5 still up one edge before timeout", power_good, 1'b1);
        @(negedge clk);
        chk("R5 down at timeout", power_good, 1'b0);
        chk("R7 permit falls with power", tx_permit, 1'b0);

        // R7: count restarts after wake; R5: an edge restarts the gap
        pulse_rx();
        chk("R2 wake on fs_rx", power_good, 1'b1);
        chk("R7 permit low after new wake", tx_permit, 1'b0);
        pulse_tx();
        chk("R7 one frame counted only", tx_permit, 1'b0);
        repeat (IDLE - 5) @(negedge clk);
        pulse_rx();
        repeat (IDLE - 2) @(negedge clk);
        chk("R5 gap restarted by fs_rx", power_good, 1'b1);
        pulse_tx();
        chk("R6 permit on second fs_tx edge", tx_permit, 1'b1);

        // R3: steady high pin forces power-down after the window
        pdn_pin = 1'b1;
        repeat (WIN) @(negedge clk);
        chk("R3 still up inside window", power_good, 1'b1);
        repeat (6) @(negedge clk);
        chk("R3 down after window", power_good, 0);
        chk("R7 permit low when forced down", tx_permit, 1'b0);
        pulse_tx();
        @(negedge clk);
        chk("R3 fs_tx ignored while pin high", power_good, 1'b0);
        pulse_rx();
        @(negedge clk);
        chk("R3 fs_rx ignored while pin high", power_good, 1'b0);

        // R4: a toggling pin counts as low
        for (int c = 0; c < 30; c++) begin
            pdn_pin = ((c / 3) % 2 == 0) ? 1'b0 : 1'b1;
            fs_tx = (c == 10);
            @(negedge clk);
            if (c == 12) chk("R4 wake with toggling pin", power_good, 1'b1);
        end
        fs_tx = 1'b0;
        chk("R4 stays up while toggling", power_good, 1'b1);
        pdn_pin = 1'b1;
        repeat (WIN + 6) @(negedge clk);
        chk("R3 down once toggling stops high", power_good, 1'b0);

        // R6: waking edge on fs_tx counts as the first frame
        pdn_pin = 1'b0;
        repeat (4) @(negedge clk);
        pulse_tx();
        chk("R2 wake on fs_tx", power_good, 1'b1);
        chk("R6 permit held after waking edge", tx_permit, 1'b0);
        @(negedge clk);
        pulse_tx();
        chk("R6 permit after second fs_tx", tx_permit, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule